// File: doc/BRIEF.md
# Incremental Sigma-Delta Reconstruction Filter

This block is the digital back end of a multi-channel incremental sigma-delta converter. It receives one single-bit modulator decision per modulator clock. It maps each bit to +1 or −1 and feeds it through three cascaded delayed accumulators. When a conversion ends, it combines the three accumulator values with three programmable signed weights: the first and second order terms are added and the third order term is subtracted. The combined value is the conversion result.

The block also sequences the conversions. It counts modulator cycles against a programmable conversion length. It drives the reset line of the modulator, clears its own accumulators at every conversion boundary, and steps a channel index through eight channels. Each finished conversion appears on the output as a one-cycle strobe that carries a channel tag. Successive conversions run back to back with no idle cycle, so the result rate is the modulator clock divided by the conversion length.

Top module: `isd_recon_filter`

## Requirements
- R1: Each modulator bit is taken as +1 when it is 1 and as −1 when it is 0. After a conversion of N samples x1..xN, the result equals α·S1 + β·S2 − γ·S3, with S1 = Σ xi, S2 = Σ xi·(N−i) and S3 = Σ xi·(N−i)(N−i−1)/2. A conversion of all ones gives α·N + β·N(N−1)/2 − γ·N(N−1)(N−2)/6.
- R2: The three stages are delayed accumulators. A sample contributes to the second stage only from the cycle after it enters the first stage, and to the third stage one cycle after that (see the weights in R1).
- R3: The third-order term enters the result with a negative sign. With only γ nonzero and all-ones input, the result is −γ·N(N−1)(N−2)/6.
- R4: The conversion length N is read from `cfgLen` at the start edge and again at every conversion boundary edge. A change of `cfgLen` during a conversion takes effect only from the next conversion. Result strobes are exactly N cycles apart.
- R5: `resValid` is high for exactly one cycle per conversion. This is the cycle after the edge that takes the Nth sample. `resData` holds its value until the next strobe.
- R6: `resChan` tags each result with the channel index. The first result after a start carries tag 0, and each later result carries the next tag modulo 8.
- R7: `modReset` stays high while the block is idle. While running, it is high for exactly the first cycle of every conversion, which is also the cycle in which `resValid` is high.
- R8: All accumulators are cleared at every conversion boundary, so a result depends only on the bits of its own conversion.
- R9: A `start` pulse while running abandons the current conversion without a strobe. It restarts the count, resets the channel index to 0 and clears the accumulators.
- R10: A synchronous `rst` stops the block. While it is held, `resValid` is 0, `resChan` is 0, `resData` is 0 and `modReset` is 1.
- R11: A `cfgLen` value below 2 is treated as a length of 2.
- R12: The weights are sampled at the boundary edge that ends a conversion. Changing them afterwards does not alter the result being held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts or restarts conversion sequencing, active high |
| cfgLen | input | 7 | Conversion length N in modulator cycles |
| wAlpha | input | 16 | First-order weight, signed Q2.14 |
| wBeta | input | 16 | Second-order weight, signed Q2.14 |
| wGamma | input | 16 | Third-order weight (subtracted), signed Q2.14 |
| modBit | input | 1 | Single-bit modulator decision |
| modReset | output | 1 | Reset to the modulator, high in the first cycle of each conversion and while idle |
| resValid | output | 1 | One-cycle strobe marking a new result |
| resChan | output | 3 | Channel tag of the result |
| resData | output | 39 | Signed weighted sum, scaled by 2^14 |

## Verification
The hardest situation to reach is one where a setting changes inside a conversion while its old value still governs that conversion. Examples are a new length written mid-conversion, new weights written just after a boundary, and a restart that lands partway through a conversion. The stimulus reaches these cases by writing `cfgLen` or the weights a few cycles after a strobe, or by pulsing `start` mid-conversion. The expected strobe spacing and held data come from a behavioural model that keeps the bits of the current conversion in a queue. Length-2 conversions, which come from a `cfgLen` of 0 or 1, put two boundaries two cycles apart and test the one-cycle strobe width under the tightest spacing.

// File: rtl/isd_pkg.sv
package isd_pkg;
  // Strobes from sequencing control to the accumulator datapath
  typedef struct packed {
    logic clear;  // zero all stages this edge
    logic accum;  // advance all stages this edge
    logic snap;   // capture final stage values and weights
  } isdStrobe_t;
endpackage

// File: rtl/isd_ctrl.sv
module isd_ctrl
  import isd_pkg::*;
#(
  parameter int N_W  = 7,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [N_W-1:0]  cfgLen,
  output isdStrobe_t      strobe,
  output logic            modReset,
  output logic            resValid,
  output logic [CH_W-1:0] resChan
);
  localparam logic [N_W-1:0] MIN_LEN = N_W'(2);

  logic            running;
  logic [N_W-1:0]  cnt;
  logic [N_W-1:0]  nLat;
  logic [N_W-1:0]  effLen;
  logic [CH_W-1:0] chanIdx;
  logic            lastCycle;

  // Lengths under the floor are raised to it
  assign effLen    = (cfgLen < MIN_LEN) ? MIN_LEN : cfgLen;
  assign lastCycle = running && (cnt == nLat - N_W'(1));

  always_comb begin
    strobe.accum = running && !start;
    strobe.snap  = lastCycle && !start;
    strobe.clear = start || (lastCycle && !start);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      cnt      <= '0;
      nLat     <= MIN_LEN;
      chanIdx  <= '0;
      modReset <= 1'b1;
      resValid <= 1'b0;
      resChan  <= '0;
    end else if (start) begin
      running  <= 1'b1;
      cnt      <= '0;
      nLat     <= effLen;
      chanIdx  <= '0;
      modReset <= 1'b1;
      resValid <= 1'b0;
    end else if (running) begin
      if (lastCycle) begin
        cnt      <= '0;
        nLat     <= effLen;
        chanIdx  <= chanIdx + CH_W'(1);
        modReset <= 1'b1;
        resValid <= 1'b1;
        resChan  <= chanIdx;
      end else begin
        cnt      <= cnt + N_W'(1);
        modReset <= 1'b0;
        resValid <= 1'b0;
      end
    end else begin
      modReset <= 1'b1;
      resValid <= 1'b0;
    end
  end

  // R5: strobe never lasts two cycles
  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    resValid |=> !resValid);
  // R7: modulator reset accompanies every result strobe
  p_valid_modrst_r7: assert property (@(posedge clk) disable iff (rst)
    resValid |-> modReset);
  // R7: modulator held in reset while idle
  p_idle_modrst_r7: assert property (@(posedge clk) disable iff (rst)
    !running |-> modReset);
  // R11: latched length never below the floor
  p_len_floor_r11: assert property (@(posedge clk) disable iff (rst)
    running |-> (nLat >= MIN_LEN));
  // R4: cycle count stays inside the latched length
  p_cnt_inside_r4: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt < nLat));
endmodule

// File: rtl/isd_datapath.sv
module isd_datapath
  import isd_pkg::*;
#(
  parameter int N_W = 7,
  parameter int W_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  isdStrobe_t             strobe,
  input  logic                   modBit,
  input  logic signed [W_W-1:0]  wAlpha,
  input  logic signed [W_W-1:0]  wBeta,
  input  logic signed [W_W-1:0]  wGamma,
  output logic signed [W_W+3*N_W+1:0] resData
);
  localparam int STAGES = 3;
  localparam int ACC_W  = 3 * N_W;
  localparam int OUT_W  = W_W + ACC_W + 2;
  localparam int LIM1   = 1 << N_W;

  logic signed [ACC_W-1:0] acc     [STAGES];
  logic signed [ACC_W-1:0] accNext [STAGES];
  logic signed [ACC_W-1:0] snapV   [STAGES];
  logic signed [ACC_W-1:0] stepIn;
  logic signed [W_W-1:0]   wAq, wBq, wGq;
  logic signed [OUT_W-1:0] termA, termB, termG;

  // Two-level bit mapped to +1 / -1
  assign stepIn = modBit ? ACC_W'(1) : {ACC_W{1'b1}};

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign accNext[k] = acc[k] + stepIn;
    end else begin : g_tail
      // Delayed accumulation: add the upstream stage's registered value
      assign accNext[k] = acc[k] + acc[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) begin
        acc[k]   <= '0;
        snapV[k] <= '0;
      end
      wAq <= '0;
      wBq <= '0;
      wGq <= '0;
    end else begin
      for (int k = 0; k < STAGES; k++) begin
        if (strobe.clear)      acc[k] <= '0;
        else if (strobe.accum) acc[k] <= accNext[k];
        if (strobe.snap)       snapV[k] <= accNext[k];
      end
      if (strobe.snap) begin
        wAq <= wAlpha;
        wBq <= wBeta;
        wGq <= wGamma;
      end
    end
  end

  assign termA   = OUT_W'(wAq) * OUT_W'(snapV[0]);
  assign termB   = OUT_W'(wBq) * OUT_W'(snapV[1]);
  assign termG   = OUT_W'(wGq) * OUT_W'(snapV[2]);
  assign resData = termA + termB - termG;

  // R8: a boundary leaves every stage at zero
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    strobe.clear |=> (acc[0] == '0 && acc[1] == '0 && acc[2] == '0));
  // R2: first stage moves by exactly one per absorbed sample
  p_stage_step_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe.accum && !strobe.clear) |=>
      ((acc[0] == $past(acc[0]) + 1) || (acc[0] == $past(acc[0]) - 1)));
  // R2: first stage bounded by the longest conversion
  p_first_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (acc[0] <= LIM1) && (acc[0] >= -LIM1));
  // R12: held result only changes on a capture
  p_hold_data_r12: assert property (@(posedge clk) disable iff (rst)
    !strobe.snap |=> $stable(resData));
endmodule

// File: rtl/isd_recon_filter.sv
module isd_recon_filter #(
  parameter int N_W  = 7,
  parameter int W_W  = 16,
  parameter int CH_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [N_W-1:0]               cfgLen,
  input  logic signed [W_W-1:0]        wAlpha,
  input  logic signed [W_W-1:0]        wBeta,
  input  logic signed [W_W-1:0]        wGamma,
  input  logic                         modBit,
  output logic                         modReset,
  output logic                         resValid,
  output logic [CH_W-1:0]              resChan,
  output logic signed [W_W+3*N_W+1:0]  resData
);
  isd_pkg::isdStrobe_t strobe;

  isd_ctrl #(.N_W(N_W), .CH_W(CH_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cfgLen   (cfgLen),
    .strobe   (strobe),
    .modReset (modReset),
    .resValid (resValid),
    .resChan  (resChan)
  );

  isd_datapath #(.N_W(N_W), .W_W(W_W)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .modBit  (modBit),
    .wAlpha  (wAlpha),
    .wBeta   (wBeta),
    .wGamma  (wGamma),
    .resData (resData)
  );
endmodule

// File: tb/isd_recon_filter_tb_top.sv
module isd_recon_filter_tb_top;
  localparam int N_W = 7, W_W = 16, CH_W = 3;
  localparam int OUT_W = W_W + 3 * N_W + 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, modBit = 1'b0;
  logic [N_W-1:0] cfgLen = 7'd80;
  logic signed [W_W-1:0] wAlpha = '0, wBeta = '0, wGamma = '0;
  logic modReset, resValid;
  logic [CH_W-1:0] resChan;
  logic signed [OUT_W-1:0] resData;

  int errors = 0, checks = 0, cycles = 0;
  int bitMode = 0;         // 0 random, 1 ones, 2 zeros, 3 alternating
  string phaseReq = "R1";

  always #2 clk = ~clk;

  isd_recon_filter dut_i (
    .clk(clk), .rst(rst), .start(start), .cfgLen(cfgLen),
    .wAlpha(wAlpha), .wBeta(wBeta), .wGamma(wGamma), .modBit(modBit),
    .modReset(modReset), .resValid(resValid), .resChan(resChan), .resData(resData)
  );

  function automatic void chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // ---------------- behavioural reference model ----------------
  bit armed = 0, mRun = 0, mValid = 0, mModRst = 1;
  int mCnt = 0, mLen = 2, mChan = 0, mTag = 0;
  longint mData = 0;
  bit bitsQ[$];

  function automatic int clampLen(int v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic longint weigh(longint a, longint b, longint g);
    longint s1 = 0, s2 = 0, s3 = 0;
    int k = bitsQ.size();
    foreach (bitsQ[i]) begin
      longint x = bitsQ[i] ? 1 : -1;
      longint d = k - 1 - i;
      s1 += x;
      s2 += x * d;
      s3 += x * d * (d - 1) / 2;
    end
    return a * s1 + b * s2 - g * s3;
  endfunction

  always @(posedge clk) begin
    armed <= 1'b1;
    if (rst) begin
      mRun = 0; mValid = 0; mModRst = 1; mData = 0; mChan = 0; mTag = 0; mCnt = 0;
      bitsQ.delete();
    end else if (start) begin
      mRun = 1; mCnt = 0; mLen = clampLen(int'(cfgLen)); mChan = 0;
      mValid = 0; mModRst = 1; bitsQ.delete();
    end else if (mRun) begin
      bitsQ.push_back(modBit);
      if (mCnt == mLen - 1) begin
        mData = weigh(longint'(wAlpha), longint'(wBeta), longint'(wGamma));
        mValid = 1; mModRst = 1; mTag = mChan; mChan = (mChan + 1) % 8;
        mCnt = 0; mLen = clampLen(int'(cfgLen)); bitsQ.delete();
      end else begin
        mCnt++; mValid = 0; mModRst = 0;
      end
    end else begin
      mValid = 0; mModRst = 1;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (armed) begin
      chk(modReset === mModRst, "R7 modReset", longint'(modReset), longint'(mModRst));
      chk(resValid === mValid, "R5 resValid", longint'(resValid), longint'(mValid));
      if (mValid)
        chk(resChan === CH_W'(mTag), "R6 resChan", longint'(resChan), longint'(mTag));
      chk(longint'(resData) == mData, mValid ? phaseReq : "R12 held",
          longint'(resData), mData);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  bit altBit = 0;
  task automatic step();
    @(negedge clk);
    case (bitMode)
      1: modBit = 1'b1;
      2: modBit = 1'b0;
      3: begin altBit = ~altBit; modBit = altBit; end
      default: modBit = 1'($urandom_range(0, 1));
    endcase
  endtask

  task automatic waitValid(output int cyc);
    cyc = 0;
    do begin
      step();
      cyc++;
    end while (!resValid && cyc < 400);
  endtask

  task automatic pulseStart();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  initial begin
    int cyc;
    longint held;
    bitMode = 1;
    repeat (3) step();
    // R10: state while reset held
    chk(resValid === 1'b0, "R10 valid", longint'(resValid), 0);
    chk(resChan === '0, "R10 chan", longint'(resChan), 0);
    chk(resData === '0, "R10 data", longint'(resData), 0);
    chk(modReset === 1'b1, "R10 modReset", longint'(modReset), 1);
    rst = 1'b0;
    repeat (3) step();
    chk(modReset === 1'b1, "R7 idle", longint'(modReset), 1);

    // R1: all-ones closed form, N=80
    phaseReq = "R1";
    wAlpha = 16'sd8192; wBeta = 16'sd300; wGamma = 16'sd5; cfgLen = 7'd80;
    pulseStart();
    waitValid(cyc);
    chk(cyc == 80, "R4 first period", cyc, 80);
    chk(longint'(resData) == 8192 * 80 + 300 * 3160 - 5 * 82160, "R1 ones",
        longint'(resData), 8192 * 80 + 300 * 3160 - 5 * 82160);
    chk(resChan == 0, "R6 first tag", longint'(resChan), 0);

    // R4: mid-conversion length change takes effect one conversion later
    phaseReq = "R4";
    bitMode = 0;
    cfgLen = 7'd20;
    waitValid(cyc);
    chk(cyc == 80, "R4 old length kept", cyc, 80);
    waitValid(cyc);
    chk(cyc == 20, "R4 new length", cyc, 20);

    // R8: random bits and weights across several conversions (model compare)
    phaseReq = "R8";
    cfgLen = 7'd37;
    for (int n = 0; n < 10; n++) begin
      wAlpha = W_W'($urandom); wBeta = W_W'($urandom); wGamma = W_W'($urandom);
      bitMode = n % 4;
      waitValid(cyc);
    end

    // R3: only the subtracted term
    phaseReq = "R3";
    bitMode = 1; wAlpha = 0; wBeta = 0; wGamma = 16'sd16384; cfgLen = 7'd10;
    pulseStart();
    waitValid(cyc);
    chk(longint'(resData) == -16384 * 120, "R3 gamma only", longint'(resData), -16384 * 120);

    // R2: delayed second stage, all zeros (-1 each)
    phaseReq = "R2";
    bitMode = 2; wGamma = 0; wBeta = 16'sd16384;
    pulseStart();
    waitValid(cyc);
    chk(longint'(resData) == -16384 * 45, "R2 beta only", longint'(resData), -16384 * 45);

    // R12: weights changed after capture leave held result alone
    held = longint'(resData);
    wBeta = 16'sd77; wAlpha = 16'sd5;
    repeat (4) step();
    chk(longint'(resData) == held, "R12 weights after capture", longint'(resData), held);

    // R11: short lengths
    phaseReq = "R11";
    bitMode = 0; cfgLen = 7'd0;
    pulseStart();
    waitValid(cyc);
    chk(cyc == 2, "R11 len 0", cyc, 2);
    cfgLen = 7'd1;
    waitValid(cyc);
    chk(cyc == 2, "R11 len 0 second", cyc, 2);
    waitValid(cyc);
    chk(cyc == 2, "R11 len 1", cyc, 2);

    // R9: restart mid-conversion
    phaseReq = "R9";
    cfgLen = 7'd30;
    pulseStart();
    repeat (3) step();
    waitValid(cyc);  // finishes the length-2/1 residue cleanly? no: started fresh
    chk(cyc == 27, "R9 baseline period", cyc, 27);
    repeat (10) step();
    pulseStart();
    waitValid(cyc);
    chk(cyc == 30, "R9 restart period", cyc, 30);
    chk(resChan == 0, "R9 tag after restart", longint'(resChan), 0);

    // R6: tag wraps after eight conversions
    phaseReq = "R6";
    cfgLen = 7'd4;
    pulseStart();
    for (int n = 0; n < 10; n++) begin
      waitValid(cyc);
      chk(int'(resChan) == n % 8, "R6 tag sequence", longint'(resChan), n % 8);
    end

    // R10: reset while running
    repeat (2) step();
    rst = 1'b1;
    step();
    chk(resValid === 1'b0, "R10 valid mid-run", longint'(resValid), 0);
    chk(resData === '0, "R10 data mid-run", longint'(resData), 0);
    chk(modReset === 1'b1, "R10 modReset mid-run", longint'(modReset), 1);
    rst = 1'b0;
    repeat (6) step();
    chk(resValid === 1'b0, "R10 stays idle", longint'(resValid), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule